// File: doc/BRIEF.md
# Serial-Load DAC Code Register

This block is the digital front end of a 16-bit voltage-output converter. A host writes a code over a three-wire serial link: an active-low frame select, a serial clock and a data line. Each frame carries one word, most significant bit first. The block samples the three serial lines with its own system clock and collects the bits in a shift register. When the frame select is released, it copies the word into the parallel code latch that drives the converter.

A frame counts as valid only if exactly as many serial clock rising edges as the code width arrived while the select was low. A frame with any other count leaves the latch unchanged and raises a sticky error flag. An active-low clear forces the latch to the reset code at once, with no clock needed. The system reset loads the same code. A parameter chooses that code: zero-scale for unipolar use, or mid-scale for bipolar use. A one-cycle pulse marks every latch update.

Top module: `dac_serial_front`

## Requirements
- R1: While `rst_ni` is low, and after it is released, `code_o` equals the reset code, `frame_err_o` is 0 and `load_o` is 0. The reset code is 0x8000 when `MIDSCALE`=1 (the default) and 0x0000 when `MIDSCALE`=0.
- R2: While `cs_ni` is low, one bit of `din_i` is captured on each rising edge of `sclk_i`. The first bit becomes bit 15 and the sixteenth becomes bit 0. A valid frame loads that word into `code_o`.
- R3: `code_o` does not change when the sixteenth serial clock edge arrives. It changes on the third rising edge of `clk_i` after `cs_ni` rises (`SYNC_STAGES`+1 with the default of 2), and only at that point.
- R4: `load_o` is high for exactly one `clk_i` cycle for each valid frame: the cycle in which `code_o` takes the new word. It stays low for invalid frames.
- R5: If `cs_ni` rises after any number of serial clock rising edges other than 16 (including 0 and more than 16), `code_o` keeps its previous value and `frame_err_o` becomes 1.
- R6: `frame_err_o` stays at 1 through later idle time and returns to 0 only when a later valid frame loads the latch.
- R7: Serial clock edges while `cs_ni` is high have no effect. Each falling edge of `cs_ni` empties the bit count and the shift register, so the frame that follows decodes correctly.
- R8: While `clr_ni` is low, `code_o` equals the reset code. It takes that value without waiting for a `clk_i` edge.
- R9: A clear during a frame leaves the bits already received in place. If the frame completes after `clr_ni` returns high, it loads its full word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock used to sample the serial lines |
| rst_ni | input | 1 | Active-low asynchronous reset (power-on) |
| clr_ni | input | 1 | Active-low asynchronous clear of the code latch |
| cs_ni | input | 1 | Active-low frame select |
| sclk_i | input | 1 | Serial clock; data is captured on its rising edge |
| din_i | input | 1 | Serial data, MSB first |
| code_o | output | 16 | Latched converter code |
| load_o | output | 1 | One-cycle pulse on each latch update |
| frame_err_o | output | 1 | Sticky flag for a frame with a wrong bit count |

## Verification
On every cycle the assertions check that the latch moves only together with a load pulse, and that each load pulse follows a select release and lasts one cycle. They also check that a short or long frame sets the error flag, that a clear holds the reset code, and that the shift register and count stay frozen or empty around select edges. The bench scenarios are needed for the rest. Only they show that the word lands in the right bit order, that the latch changes exactly three clock edges after release, that a clear applied mid-frame still lets the frame complete, and that idle serial clocks leave no trace in the next frame.

// File: rtl/dac_serial_pkg.sv
package dac_serial_pkg;

  function automatic logic [15:0] reset_code(input bit midscale);
    return midscale ? 16'h8000 : 16'h0000;
  endfunction

  typedef struct packed {
    logic cs_n;
    logic sclk;
    logic din;
  } serial_lines_t;

endpackage

// File: rtl/dac_serial_sync.sv
module dac_serial_sync #(
  parameter int unsigned      WIDTH   = 3,
  parameter int unsigned      STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= RST_VAL;
    end else begin
      stage_q[0] <= async_i;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
    end
  end

  assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/dac_serial_rx.sv
module dac_serial_rx #(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned CNT_MAX = DATA_W + 1,
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_n_i,
  input  logic              sclk_i,
  input  logic              din_i,
  output logic [DATA_W-1:0] shift_o,
  output logic [CNT_W-1:0]  cnt_o,
  output logic              cs_rise_o
);

  logic              cs_prev_q, sclk_prev_q;
  logic              cs_fall, sclk_rise;
  logic [DATA_W-1:0] shift_q;
  logic [CNT_W-1:0]  cnt_q;

  assign cs_fall   = cs_prev_q & ~cs_n_i;
  assign cs_rise_o = ~cs_prev_q & cs_n_i;
  assign sclk_rise = ~sclk_prev_q & sclk_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_prev_q   <= 1'b1;
      sclk_prev_q <= 1'b0;
    end else begin
      cs_prev_q   <= cs_n_i;
      sclk_prev_q <= sclk_i;
    end
  end

  // count saturates one past the frame length: any overrun stays invalid
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      shift_q <= '0;
      cnt_q   <= '0;
    end else if (cs_fall) begin
      shift_q <= '0;
      cnt_q   <= '0;
    end else if (!cs_n_i && sclk_rise) begin
      shift_q <= {shift_q[DATA_W-2:0], din_i};
      if (cnt_q != CNT_W'(CNT_MAX)) cnt_q <= cnt_q + 1'b1;
    end
  end

  assign shift_o = shift_q;
  assign cnt_o   = cnt_q;

  AST_CNT_EMPTY_AFTER_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_fall |=> (cnt_q == '0)) else $error("count not emptied"); // R7

  AST_IDLE_NO_SHIFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |=> $stable(shift_q) && $stable(cnt_q)) else $error("shift while idle"); // R7

  AST_CNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(CNT_MAX)) else $error("count overrun"); // R5

endmodule

// File: rtl/dac_code_latch.sv
module dac_code_latch
  import dac_serial_pkg::*;
#(
  parameter int unsigned DATA_W   = 16,
  parameter bit          MIDSCALE = 1'b1,
  localparam int unsigned CNT_W   = $clog2(DATA_W + 2),
  localparam logic [DATA_W-1:0] RST_CODE = DATA_W'(reset_code(MIDSCALE))
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_ni,
  input  logic              cs_rise_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic [DATA_W-1:0] shift_i,
  output logic [DATA_W-1:0] code_o,
  output logic              load_o,
  output logic              err_o
);

  logic              frame_ok;
  logic [DATA_W-1:0] code_q;
  logic              load_q, err_q;

  assign frame_ok = cs_rise_i && (cnt_i == CNT_W'(DATA_W));

  always_ff @(posedge clk_i or negedge rst_ni or negedge clr_ni) begin
    if (!rst_ni) begin
      code_q <= RST_CODE;
      load_q <= 1'b0;
    end else if (!clr_ni) begin
      code_q <= RST_CODE;
      load_q <= 1'b0;
    end else begin
      load_q <= frame_ok;
      if (frame_ok) code_q <= shift_i;
    end
  end

  // error flag survives a clear; only reset or a good frame drops it
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) err_q <= 1'b0;
    else if (cs_rise_i) err_q <= ~frame_ok;
  end

  assign code_o = code_q;
  assign load_o = load_q;
  assign err_o  = err_q;

  AST_LOAD_AFTER_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_q |-> $past(cs_rise_i)) else $error("load without release"); // R3

  AST_LOAD_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_q |=> !load_q) else $error("load pulse too long"); // R4

  AST_BAD_FRAME_FLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_rise_i && cnt_i != CNT_W'(DATA_W)) |=> err_q) else $error("bad frame not flagged"); // R5

  AST_GOOD_FRAME_UNFLAG: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_q |-> !err_q) else $error("error kept after good frame"); // R6

  AST_CLR_HOLDS_CODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !clr_ni |-> code_q == RST_CODE) else $error("clear not applied"); // R8

endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front
  import dac_serial_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned SYNC_STAGES = 2,
  parameter bit          MIDSCALE    = 1'b1,
  localparam int unsigned CNT_W      = $clog2(DATA_W + 2)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_ni,
  input  logic              cs_ni,
  input  logic              sclk_i,
  input  logic              din_i,
  output logic [DATA_W-1:0] code_o,
  output logic              load_o,
  output logic              frame_err_o
);

  serial_lines_t     raw_lines, sync_lines;
  logic [DATA_W-1:0] shift;
  logic [CNT_W-1:0]  cnt;
  logic              cs_rise;

  assign raw_lines = '{cs_n: cs_ni, sclk: sclk_i, din: din_i};

  dac_serial_sync #(
    .WIDTH   ($bits(serial_lines_t)),
    .STAGES  (SYNC_STAGES),
    .RST_VAL (3'b100)
  ) u_sync (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .async_i (raw_lines),
    .sync_o  (sync_lines)
  );

  dac_serial_rx #(
    .DATA_W (DATA_W)
  ) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cs_n_i    (sync_lines.cs_n),
    .sclk_i    (sync_lines.sclk),
    .din_i     (sync_lines.din),
    .shift_o   (shift),
    .cnt_o     (cnt),
    .cs_rise_o (cs_rise)
  );

  dac_code_latch #(
    .DATA_W   (DATA_W),
    .MIDSCALE (MIDSCALE)
  ) u_latch (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_ni    (clr_ni),
    .cs_rise_i (cs_rise),
    .cnt_i     (cnt),
    .shift_i   (shift),
    .code_o    (code_o),
    .load_o    (load_o),
    .err_o     (frame_err_o)
  );

  AST_CODE_MOVES_ON_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni || !clr_ni)
    !load_o |-> $stable(code_o)) else $error("code changed without load"); // R3

endmodule

// File: tb/dac_serial_front_tb.sv
module dac_serial_front_tb;

  localparam int HALF = 3;
  localparam logic [15:0] RST_EXP = 16'h8000;
  localparam int NVEC = 7;
  localparam logic [15:0] VEC_WORD [NVEC] =
    '{16'hA5C3, 16'h0001, 16'hFFFF, 16'h1234, 16'h8000, 16'h0000, 16'h7FFE};
  localparam int VEC_BITS [NVEC] = '{16, 16, 15, 17, 16, 0, 16};

  logic clk = 1'b0, rst_ni = 1'b0, clr_ni = 1'b1;
  logic cs_ni = 1'b1, sclk = 1'b0, din = 1'b0;
  logic [15:0] code;
  logic load, ferr;

  int checks = 0, fails = 0, loads = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dac_serial_front u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .clr_ni(clr_ni), .cs_ni(cs_ni),
    .sclk_i(sclk), .din_i(din), .code_o(code), .load_o(load), .frame_err_o(ferr)
  );

  always @(negedge clk) if (rst_ni && load) loads++;

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cs_fall();
    @(negedge clk) cs_ni = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic send_bits(input logic [15:0] w, input int n);
    for (int i = 0; i < n; i++) begin
      din = (i < 16) ? w[15-i] : 1'b0;
      wait_clk(HALF);
      sclk = 1'b1;
      wait_clk(HALF);
      sclk = 1'b0;
    end
    wait_clk(6);
  endtask

  task automatic cs_rise();
    @(negedge clk) cs_ni = 1'b1;
    wait_clk(8);
  endtask

  initial begin
    logic [15:0] model;
    int l0;
    model = RST_EXP;
    // R1 reset state
    wait_clk(3);
    check(code, RST_EXP, "R1 code in reset");
    rst_ni = 1'b1;
    wait_clk(3);
    check(code, RST_EXP, "R1 code after reset");
    check({15'd0, ferr}, 16'd0, "R1 error after reset");
    check({15'd0, load}, 16'd0, "R1 load after reset");

    // vector table: R2 R3 R4 R5 R6
    for (int v = 0; v < NVEC; v++) begin
      logic ok;
      ok = (VEC_BITS[v] == 16);
      l0 = loads;
      cs_fall();
      send_bits(VEC_WORD[v], VEC_BITS[v]);
      check(code, model, "R3 no update before release");
      cs_rise();
      if (ok) model = VEC_WORD[v];
      check(code, model, ok ? "R2 word loaded" : "R5 code kept on bad frame");
      check({15'd0, ferr}, {15'd0, !ok}, ok ? "R6 error cleared" : "R5 error set");
      check(16'(loads - l0), ok ? 16'd1 : 16'd0, "R4 load pulse count");
      wait_clk(10);
      check({15'd0, ferr}, {15'd0, !ok}, "R6 error sticky while idle");
    end

    // R3 exact latency after release
    cs_fall();
    send_bits(16'h3C5A, 16);
    @(negedge clk) cs_ni = 1'b1;
    wait_clk(2);
    check(code, model, "R3 old code two edges after release");
    wait_clk(1);
    check(code, 16'h3C5A, "R3 new code on third edge");
    model = 16'h3C5A;
    wait_clk(6);

    // R7 idle serial clocks ignored
    din = 1'b1;
    for (int i = 0; i < 20; i++) begin
      wait_clk(HALF); sclk = 1'b1; wait_clk(HALF); sclk = 1'b0;
    end
    wait_clk(6);
    check(code, model, "R7 idle clocks leave code");
    cs_fall();
    send_bits(16'h0F0F, 16);
    cs_rise();
    check(code, 16'h0F0F, "R7 frame after idle clocks");
    check({15'd0, ferr}, 16'd0, "R7 no error after idle clocks");
    model = 16'h0F0F;

    // R8 asynchronous clear
    @(negedge clk);
    #3 clr_ni = 1'b0;
    #2 check(code, RST_EXP, "R8 clear without clock edge");
    wait_clk(4);
    check(code, RST_EXP, "R8 clear holds");
    clr_ni = 1'b1;
    wait_clk(4);
    check(code, RST_EXP, "R8 reset code after clear release");
    model = RST_EXP;

    // R9 clear mid-frame
    cs_fall();
    send_bits(16'hBEEF, 8);
    clr_ni = 1'b0;
    wait_clk(5);
    check(code, RST_EXP, "R9 clear during frame");
    clr_ni = 1'b1;
    wait_clk(2);
    send_bits({8'hEF, 8'h00}, 8);
    cs_rise();
    check(code, 16'hBEEF, "R9 frame completes after clear");

    // R1 reset during operation
    rst_ni = 1'b0;
    wait_clk(2);
    check(code, RST_EXP, "R1 code on later reset");
    rst_ni = 1'b1;
    wait_clk(2);
    check({15'd0, ferr}, 16'd0, "R1 error on later reset");

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule